// File: doc/BRIEF.md
# Sampled-Clock Multi-Port RAM

This block is a small multi-port RAM for designs that must run entirely on one fast global clock. Some of its write ports are nominally owned by slower clock signals. The RAM does not use those slower clocks as clocks. Each one enters as an ordinary data bit, and each clocked write port turns it into a one-cycle write pulse.

A clocked write port holds the value its clock input had on the previous global cycle. It compares that value with the present one to find its active edge, which is either rising or falling. The port also keeps one-cycle-old copies of its enable, address and data. It commits that copy on the global edge that ends the cycle in which the slow edge is seen. A port marked as unclocked skips this path and writes its live inputs on every global edge.

Reads are purely combinational. A configuration that asks for a registered read port stops elaboration. Every width and count is a parameter, and two per-port bit vectors set which write ports are clocked and which edge each one uses.

Top module: `sclk_ram`

## Requirements
- R1: While rst_ni is low, every word of the array reads as zero.
- R2: A rising-edge write port writes only when its clock sample was 0 on the previous global cycle and is 1 now. The write uses the enable, address and data sampled on the previous global cycle. In the default configuration this is port 0.
- R3: A falling-edge write port writes only when its clock sample was 1 on the previous global cycle and is 0 now. It also uses the previous cycle's enable, address and data. In the default configuration this is port 1.
- R4: After reset is released, a clocked port that holds its clock at any constant level produces no write. The stored previous sample starts at the port's active level: 1 for rising-edge ports, 0 for falling-edge ports.
- R5: The write enable has one bit per data bit. Bit i of a port's enable slice selects data bit i. Only the enabled bits of the addressed word change.
- R6: On a clocked port, a global cycle without an active edge changes no word, whatever the enable, address and data inputs are.
- R7: An unclocked write port writes its current enable, address and data on every global clock edge. In the default configuration this is port 2.
- R8: When several write ports update the same word on the same global edge, the higher-numbered port sets the bits it enables. Lower ports keep only the bits that no higher port enables.
- R9: Each read port returns the word at its address in the same cycle, with no clock edge needed. Read port r uses address slice r and data slice r.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast global clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_clk_i | input | NUM_WR | Sampled write clock, one bit per write port |
| wr_en_i | input | NUM_WR*DATA_W | Per-bit write enables, port p in slice p |
| wr_addr_i | input | NUM_WR*ADDR_W | Write addresses, port p in slice p |
| wr_data_i | input | NUM_WR*DATA_W | Write data, port p in slice p |
| rd_addr_i | input | NUM_RD*ADDR_W | Read addresses, port r in slice r |
| rd_data_o | output | NUM_RD*DATA_W | Combinational read data, port r in slice r |

## Verification
The directed patterns cover three cases on each clocked port:
- A held clock level, which separates a true edge detector from a level-sensitive one.
- A clock edge whose data changes in the same cycle, which shows whether the write uses the previous cycle's sample.
- Reset released with each clock already at its active level, which exposes a wrong reset value in the edge register.

Partial enables and a same-word collision between a clocked port and the unclocked port check bit merging and port priority.

Long random runs then give each clocked port its own slow divided clock, with random enables, addresses and data. Read ports are compared against a reference model on every cycle, so edge phases, overlapping writes and read-after-write all meet.

// File: rtl/sclk_ram_pkg.sv
package sclk_ram_pkg;

  // active-edge test on two successive samples of a write clock
  function automatic logic edge_hit(logic rising, logic prev, logic cur);
    return rising ? (~prev & cur) : (prev & ~cur);
  endfunction

  function automatic logic [31:0] word_count(int addr_w);
    return 32'd1 << addr_w;
  endfunction

endpackage

// File: rtl/sclk_ram_wr_port.sv
module sclk_ram_wr_port
  import sclk_ram_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter bit CLOCKED = 1'b1,
  parameter bit RISING  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wclk_i,
  input  logic [DATA_W-1:0] en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              edge_o,
  output logic [DATA_W-1:0] en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  logic              clk_prev_q;
  logic [DATA_W-1:0] en_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              hit;

  // reset to active level: a held clock never looks like an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_prev_q <= RISING;
    else         clk_prev_q <= wclk_i;
  end

  always_ff @(posedge clk_i) begin
    en_q   <= en_i;
    addr_q <= addr_i;
    data_q <= data_i;
  end

  assign hit = edge_hit(RISING, clk_prev_q, wclk_i);

  always_comb begin
    if (CLOCKED) begin
      edge_o = hit;
      en_o   = hit ? en_q : '0;
      addr_o = addr_q;
      data_o = data_q;
    end else begin
      edge_o = 1'b0;
      en_o   = en_i;
      addr_o = addr_i;
      data_o = data_i;
    end
  end

endmodule

// File: rtl/sclk_ram_store.sv
module sclk_ram_store
  import sclk_ram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int NUM_WR = 3,
  localparam int DEPTH = int'(word_count(ADDR_W))
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_WR*DATA_W-1:0] wr_en_i,
  input  logic [NUM_WR*ADDR_W-1:0] wr_addr_i,
  input  logic [NUM_WR*DATA_W-1:0] wr_data_i,
  output logic [DEPTH*DATA_W-1:0]  mem_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] mem_d [DEPTH];

  // ascending port order: later ports override earlier ones bit by bit
  always_comb begin
    mem_d = mem_q;
    for (int p = 0; p < NUM_WR; p++) begin
      mem_d[wr_addr_i[p*ADDR_W +: ADDR_W]] =
          (mem_d[wr_addr_i[p*ADDR_W +: ADDR_W]] & ~wr_en_i[p*DATA_W +: DATA_W]) |
          (wr_data_i[p*DATA_W +: DATA_W] & wr_en_i[p*DATA_W +: DATA_W]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      mem_q <= mem_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_flat
    assign mem_o[i*DATA_W +: DATA_W] = mem_q[i];
  end

endmodule

// File: rtl/sclk_ram_rd_port.sv
module sclk_ram_rd_port #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic [DEPTH*DATA_W-1:0] mem_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic [DATA_W-1:0]       data_o
);

  assign data_o = mem_i[addr_i*DATA_W +: DATA_W];

endmodule

// File: rtl/sclk_ram.sv
module sclk_ram
  import sclk_ram_pkg::*;
#(
  parameter int              ADDR_W        = 4,
  parameter int              DATA_W        = 8,
  parameter int              NUM_RD        = 2,
  parameter int              NUM_WR        = 3,
  parameter logic [NUM_WR-1:0] WR_CLOCKED  = 3'b011,
  parameter logic [NUM_WR-1:0] WR_RISING   = 3'b001,
  parameter logic [NUM_RD-1:0] RD_REGISTERED = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_WR-1:0]        wr_clk_i,
  input  logic [NUM_WR*DATA_W-1:0] wr_en_i,
  input  logic [NUM_WR*ADDR_W-1:0] wr_addr_i,
  input  logic [NUM_WR*DATA_W-1:0] wr_data_i,
  input  logic [NUM_RD*ADDR_W-1:0] rd_addr_i,
  output logic [NUM_RD*DATA_W-1:0] rd_data_o
);

  localparam int DEPTH = int'(word_count(ADDR_W));

  if (RD_REGISTERED != '0) begin : g_reject_rd
    $error("sclk_ram: registered read ports are not supported");
  end

  logic [NUM_WR-1:0]        wr_edge;
  logic [NUM_WR*DATA_W-1:0] wr_eff_en;
  logic [NUM_WR*ADDR_W-1:0] wr_eff_addr;
  logic [NUM_WR*DATA_W-1:0] wr_eff_data;
  logic [DEPTH*DATA_W-1:0]  mem_flat;

  for (genvar p = 0; p < NUM_WR; p++) begin : g_wr
    sclk_ram_wr_port #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CLOCKED(WR_CLOCKED[p]),
      .RISING (WR_RISING[p])
    ) u_wr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .wclk_i(wr_clk_i[p]),
      .en_i  (wr_en_i[p*DATA_W +: DATA_W]),
      .addr_i(wr_addr_i[p*ADDR_W +: ADDR_W]),
      .data_i(wr_data_i[p*DATA_W +: DATA_W]),
      .edge_o(wr_edge[p]),
      .en_o  (wr_eff_en[p*DATA_W +: DATA_W]),
      .addr_o(wr_eff_addr[p*ADDR_W +: ADDR_W]),
      .data_o(wr_eff_data[p*DATA_W +: DATA_W])
    );
  end

  sclk_ram_store #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .NUM_WR(NUM_WR)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_eff_en),
    .wr_addr_i(wr_eff_addr),
    .wr_data_i(wr_eff_data),
    .mem_o    (mem_flat)
  );

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    sclk_ram_rd_port #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .DEPTH (DEPTH)
    ) u_rd (
      .mem_i (mem_flat),
      .addr_i(rd_addr_i[r*ADDR_W +: ADDR_W]),
      .data_o(rd_data_o[r*DATA_W +: DATA_W])
    );
  end

endmodule

// File: rtl/sclk_ram_chk.sv
module sclk_ram_chk #(
  parameter int                ADDR_W     = 4,
  parameter int                DATA_W     = 8,
  parameter int                NUM_RD     = 2,
  parameter int                NUM_WR     = 3,
  parameter logic [NUM_WR-1:0] WR_CLOCKED = 3'b011,
  parameter logic [NUM_WR-1:0] WR_RISING  = 3'b001
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_WR-1:0]        wr_clk_i,
  input logic [NUM_WR*DATA_W-1:0] wr_en_i,
  input logic [NUM_WR-1:0]        wr_edge,
  input logic [NUM_WR*DATA_W-1:0] wr_eff_en,
  input logic [NUM_RD*ADDR_W-1:0] rd_addr_i,
  input logic [NUM_RD*DATA_W-1:0] rd_data_o
);

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  for (genvar p = 0; p < NUM_WR; p++) begin : g_port
    if (WR_CLOCKED[p]) begin : g_clk
      // R2, R3
      edge_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seen_q |-> (wr_edge[p] == (WR_RISING[p] ? (!$past(wr_clk_i[p]) && wr_clk_i[p])
                                                : ($past(wr_clk_i[p]) && !wr_clk_i[p]))));
      // R6
      idle_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_edge[p] |-> (wr_eff_en[p*DATA_W +: DATA_W] == '0));
      // R2
      edge_uses_prior_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && wr_edge[p]) |->
          (wr_eff_en[p*DATA_W +: DATA_W] == $past(wr_en_i[p*DATA_W +: DATA_W])));
      // R4
      no_false_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !seen_q |-> !wr_edge[p]);
    end
  end

  // R9
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(wr_eff_en) == '0 && $stable(rd_addr_i)) |-> $stable(rd_data_o));

endmodule

bind sclk_ram sclk_ram_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .NUM_RD    (NUM_RD),
  .NUM_WR    (NUM_WR),
  .WR_CLOCKED(WR_CLOCKED),
  .WR_RISING (WR_RISING)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_clk_i (wr_clk_i),
  .wr_en_i  (wr_en_i),
  .wr_edge  (wr_edge),
  .wr_eff_en(wr_eff_en),
  .rd_addr_i(rd_addr_i),
  .rd_data_o(rd_data_o)
);

// File: tb/sclk_ram_bench.sv
module sclk_ram_bench;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NR = 2;
  localparam int NW = 3;
  localparam int DEPTH = 1 << AW;
  localparam logic [NW-1:0] CLKD = 3'b011;
  localparam logic [NW-1:0] RISE = 3'b001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NW-1:0]    wclk;
  logic [NW*DW-1:0] wen, wdata;
  logic [NW*AW-1:0] waddr;
  logic [NR*AW-1:0] raddr;
  logic [NR*DW-1:0] rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [DW-1:0] model [DEPTH];
  logic          m_prev [NW];
  logic [DW-1:0] m_en [NW];
  logic [DW-1:0] m_data [NW];
  logic [AW-1:0] m_addr [NW];

  sclk_ram u_sclk_ram (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .wr_clk_i (wclk),
    .wr_en_i  (wen),
    .wr_addr_i(waddr),
    .wr_data_i(wdata),
    .rd_addr_i(raddr),
    .rd_data_o(rdata)
  );

  function automatic void apply(logic [AW-1:0] a, logic [DW-1:0] e, logic [DW-1:0] d);
    model[a] = (model[a] & ~e) | (d & e);
  endfunction

  // model of one global edge, then advance past it
  task automatic step();
    for (int p = 0; p < NW; p++) begin
      if (rst_n) begin
        if (CLKD[p]) begin
          if (RISE[p] ? (!m_prev[p] && wclk[p]) : (m_prev[p] && !wclk[p]))
            apply(m_addr[p], m_en[p], m_data[p]);
          m_prev[p] = wclk[p];
        end else begin
          apply(waddr[p*AW +: AW], wen[p*DW +: DW], wdata[p*DW +: DW]);
        end
      end
      m_en[p]   = wen[p*DW +: DW];
      m_addr[p] = waddr[p*AW +: AW];
      m_data[p] = wdata[p*DW +: DW];
    end
    @(posedge clk);
    #2;
  endtask

  task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic check_word(string tag, logic [AW-1:0] a, logic [DW-1:0] exp);
    raddr[0 +: AW] = a;
    #1;
    check(tag, rdata[0 +: DW], exp);
  endtask

  task automatic check_all(string tag);
    for (int a = 0; a < DEPTH; a++) begin
      raddr[0 +: AW]  = AW'(a);
      raddr[AW +: AW] = AW'(DEPTH - 1 - a);
      #1;
      check(tag, rdata[0 +: DW], model[a]);
      check(tag, rdata[DW +: DW], model[DEPTH - 1 - a]);
    end
  endtask

  task automatic drive(int p, logic c, logic [DW-1:0] e, logic [AW-1:0] a, logic [DW-1:0] d);
    wclk[p]         = c;
    wen[p*DW +: DW] = e;
    waddr[p*AW +: AW] = a;
    wdata[p*DW +: DW] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=hang expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int a = 0; a < DEPTH; a++) model[a] = '0;
    for (int p = 0; p < NW; p++) begin
      m_prev[p] = RISE[p];
      m_en[p] = '0; m_addr[p] = '0; m_data[p] = '0;
    end
    raddr = '0;
    // clocks sit at active level during reset, enables on
    drive(0, 1'b1, 8'hFF, 4'd5, 8'hAA);
    drive(1, 1'b0, 8'hFF, 4'd6, 8'hBB);
    drive(2, 1'b0, 8'h00, 4'd0, 8'h00);
    step();
    step();
    check_all("R1");
    rst_n = 1'b1;
    step();
    step();
    check_word("R4", 4'd5, 8'h00);
    check_word("R4", 4'd6, 8'h00);
    drive(1, 1'b0, 8'h00, 4'd6, 8'hBB);

    // R2: rising port, data changes on the edge cycle
    drive(0, 1'b0, 8'hFF, 4'd3, 8'h5A);
    step();
    check_word("R6", 4'd3, 8'h00);
    drive(0, 1'b1, 8'h00, 4'd7, 8'h00);
    step();
    check_word("R2", 4'd3, 8'h5A);
    check_word("R2", 4'd7, 8'h00);

    // R6: level held high with enable on
    drive(0, 1'b1, 8'hFF, 4'd3, 8'h33);
    step(); step(); step();
    check_word("R6", 4'd3, 8'h5A);
    drive(0, 1'b1, 8'h00, 4'd3, 8'h33);

    // R3: falling port
    drive(1, 1'b1, 8'hFF, 4'd6, 8'hBB);
    step();
    check_word("R3", 4'd6, 8'h00);
    drive(1, 1'b1, 8'hFF, 4'd12, 8'hC3);
    step();
    drive(1, 1'b0, 8'h00, 4'd0, 8'h00);
    step();
    check_word("R3", 4'd12, 8'hC3);
    check_word("R3", 4'd6, 8'h00);

    // R5: partial enable
    drive(0, 1'b0, 8'h0F, 4'd3, 8'hFF);
    step();
    drive(0, 1'b1, 8'h00, 4'd3, 8'h00);
    step();
    check_word("R5", 4'd3, 8'h5F);

    // R7: unclocked port writes live inputs
    drive(2, 1'b0, 8'hFF, 4'd9, 8'h77);
    step();
    check_word("R7", 4'd9, 8'h77);
    drive(2, 1'b0, 8'h00, 4'd9, 8'h00);
    step();

    // R8: port 0 and port 2 hit word 10 on one edge
    drive(0, 1'b0, 8'hFF, 4'd10, 8'h11);
    step();
    drive(0, 1'b1, 8'h00, 4'd0, 8'h00);
    drive(2, 1'b0, 8'hF0, 4'd10, 8'h22);
    step();
    check_word("R8", 4'd10, 8'h21);
    drive(2, 1'b0, 8'h00, 4'd0, 8'h00);
    step();

    // R9: read address change with no clock edge
    raddr[AW +: AW] = 4'd12;
    #1 check("R9", rdata[DW +: DW], 8'hC3);
    raddr[AW +: AW] = 4'd9;
    #1 check("R9", rdata[DW +: DW], 8'h77);
    step();
    check_all("R9");

    // random mix with divided slow clocks
    for (int n = 0; n < 4000; n++) begin
      if (n % 3 == 0) wclk[0] = ~wclk[0];
      if (n % 5 == 0) wclk[1] = ~wclk[1];
      for (int p = 0; p < 2; p++) begin
        wen[p*DW +: DW]   = ($urandom_range(0, 3) == 0) ? 8'h00 : DW'($urandom);
        waddr[p*AW +: AW] = AW'($urandom);
        wdata[p*DW +: DW] = DW'($urandom);
      end
      wen[2*DW +: DW]   = ($urandom_range(0, 15) == 0) ? DW'($urandom) : 8'h00;
      waddr[2*AW +: AW] = AW'($urandom);
      wdata[2*DW +: DW] = DW'($urandom);
      step();
      raddr = (NR*AW)'($urandom);
      #1;
      for (int r = 0; r < NR; r++)
        check("R2", rdata[r*DW +: DW], model[raddr[r*AW +: AW]]);
    end
    wen = '0;
    step();
    check_all("R8");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule